// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Keyed Refresh

This block watches over running software. It counts CPU clock cycles through a prescaler whose ratio is chosen by one control input. It then counts down the prescaler ticks through a counter of 2^CNT_W steps. The full timeout is therefore the ratio times 2^CNT_W clocks. Software keeps the timer from expiring by writing two key bytes in a row to a refresh register. If it fails to do so, the counter runs past zero, reloads, and the block raises either a one-cycle interrupt or a one-cycle reset request. An external reset controller is expected to stretch that request.

A strap input is captured while the device reset is low. The strap decides whether the timer runs by itself or waits for a write to a start register. Once the timer runs, nothing short of a device reset stops it. A low-power input pauses the prescaler and the counter without losing either value. A sticky flag, cleared only by power-on reset, reports whether the most recent device reset followed a watchdog reset request.

The control flow is one state machine with three states. ST_BOOT is entered on reset. It moves to ST_WAIT when the latched strap is 1, or to ST_RUN when it is 0. ST_WAIT moves to ST_RUN on any write to the start register. ST_RUN has no exit. The refresh key is a second machine with two states. KEY_IDLE moves to KEY_ARMED on a 00h write. KEY_ARMED stays armed on another 00h write. It fires a reload and returns to KEY_IDLE on an FFh write, and returns to KEY_IDLE on any other value.

Top module: `wdt_keyed_watchdog`

## Requirements
- R1: While counting, the prescaler advances once per clock. The counter falls by one on each prescaler tick. An underflow follows every ratio x 2^CNT_W counting clocks, and count_o starts at 2^CNT_W-1.
- R2: div_sel=0 selects ratio DIV_LO and div_sel=1 selects ratio DIV_HI. The ratio is evaluated on each clock.
- R3: Register writes carry wr_sel=0 for the refresh register and wr_sel=1 for the start register. A refresh write of 00h arms the key. A refresh write of FFh while armed reloads count_o to 2^CNT_W-1 at that clock edge and disarms the key. Any other refresh value disarms without a reload, a repeated 00h keeps the key armed, and FFh while unarmed has no effect.
- R4: A reload by refresh does not clear the prescaler, so the first tick after a refresh may come early.
- R5: strap_hold is captured while rst_n is low, and changing it later has no effect. With 1, the timer stays in ST_WAIT with count_o held until any start write (wr_sel=1, any data). With 0, it enters ST_RUN at the first clock edge after reset release.
- R6: Once in ST_RUN, the timer cannot be stopped, and start writes have no effect.
- R7: While lp_hold is 1, the prescaler and counter hold their values. Counting resumes from those values when lp_hold returns to 0.
- R8: On a tick with count_o at 0, the counter reloads to 2^CNT_W-1. In the cycle that shows the reloaded value, irq_o is high for one cycle if act_rst is 0, or rst_req_o is high for one cycle if act_rst is 1. The two outputs are never high together.
- R9: If a key-completing refresh write falls on the same clock as an underflow tick, the refresh takes precedence: the counter reloads and neither irq_o nor rst_req_o pulses.
- R10: wdt_flag_o becomes 1 when rst_n is asserted after a rst_req_o pulse, and becomes 0 when rst_n is asserted with no pulse since the previous reset. por_n clears it.
- R11: During reset, count_o is 2^CNT_W-1 and irq_o and rst_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, count source |
| por_n | input | 1 | Power-on reset, active low, clears the cause flag |
| rst_n | input | 1 | Device reset, active low |
| strap_hold | input | 1 | Start mode captured during reset: 1 waits for start write |
| div_sel | input | 1 | Prescaler ratio select |
| act_rst | input | 1 | Underflow action: 0 interrupt, 1 reset request |
| lp_hold | input | 1 | Low-power freeze of prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 refresh, 1 start |
| wr_data | input | 8 | Write data |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Watchdog interrupt pulse |
| rst_req_o | output | 1 | Watchdog reset request pulse |
| wdt_flag_o | output | 1 | Last device reset was caused by the watchdog |

## Verification
The collision that matters is a key-completing FFh refresh arriving on the same clock as the prescaler tick that would take the counter past zero. The bench follows its own model of the prescaler phase. It places the arming 00h write one clock before the final tick and the FFh write on the tick itself. It then expects count_o at full value with no irq_o pulse. Random traffic also lands refresh writes on low-power edges and ratio changes. Every cycle is compared with the model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {ST_BOOT, ST_WAIT, ST_RUN} run_st_t;
    typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_t;
    localparam logic [7:0] KEY_ARM  = 8'h00;
    localparam logic [7:0] KEY_FIRE = 8'hFF;
    localparam logic SEL_REFRESH = 1'b0;
    localparam logic SEL_START   = 1'b1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic div_sel,
    output logic tick
);
    localparam int PW = (DIV_HI > DIV_LO) ? $clog2(DIV_HI) : $clog2(DIV_LO);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    assign limit = div_sel ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
    assign tick  = en && (pre_q >= limit);

    // cleared only by device reset, never by refresh
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pre_q <= '0;
        else if (en) pre_q <= tick ? '0 : pre_q + 1'b1;
    end

    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pre_q));
endmodule

// File: rtl/wdt_key.sv
module wdt_key
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       refresh
);
    key_st_t st_q, st_d;
    logic    ref_wr;

    assign ref_wr  = wr_en && (wr_sel == SEL_REFRESH);
    assign refresh = ref_wr && (st_q == KEY_ARMED) && (wr_data == KEY_FIRE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KEY_IDLE:  if (ref_wr && wr_data == KEY_ARM) st_d = KEY_ARMED;
            KEY_ARMED: if (ref_wr) st_d = (wr_data == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
            default:   st_d = KEY_IDLE;
        endcase
    end

    // R3
    key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> st_q == KEY_IDLE);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             refresh,
    output logic [CNT_W-1:0] cnt,
    output logic             uf
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    assign uf = tick && (cnt == '0) && !refresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= FULL;
        else if (refresh || uf)  cnt <= FULL;
        else if (tick)           cnt <= cnt - 1'b1;
    end

    // R3
    reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> cnt == FULL);
    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !refresh && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/wdt_keyed_watchdog.sv
module wdt_keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 128
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             strap_hold,
    input  logic             div_sel,
    input  logic             act_rst,
    input  logic             lp_hold,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic             wdt_flag_o
);
    run_st_t st_q, st_d;
    logic    strap_q;
    logic    en, tick, refresh, uf;
    logic    pend_q, rst_seen_q;

    // strap captured only while device reset is applied
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_BOOT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BOOT: st_d = strap_q ? ST_WAIT : ST_RUN;
            ST_WAIT: if (wr_en && wr_sel == SEL_START) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_BOOT;
        endcase
    end

    assign en = (st_q == ST_RUN) && !lp_hold;

    wdt_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .tick(tick)
    );

    wdt_key u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .refresh(refresh)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .refresh(refresh),
        .cnt(count_o), .uf(uf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            irq_o     <= uf && !act_rst;
            rst_req_o <= uf && act_rst;
        end
    end

    // reset cause, kept across device reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pend_q     <= 1'b0;
            wdt_flag_o <= 1'b0;
            rst_seen_q <= 1'b0;
        end else begin
            rst_seen_q <= rst_n;
            if (!rst_n && rst_seen_q) begin
                wdt_flag_o <= pend_q;
                pend_q     <= 1'b0;
            end else if (rst_req_o) begin
                pend_q <= 1'b1;
            end
        end
    end

    // R8
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R6
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_RUN |=> st_q == ST_RUN);
    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_hold && !refresh) |=> $stable(count_o));
endmodule

// File: tb/tb_wdt_keyed_watchdog.sv
module tb_wdt_keyed_watchdog;
    localparam int CNT_W  = 4;
    localparam int DIV_LO = 4;
    localparam int DIV_HI = 8;
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic strap_hold = 1'b0, div_sel = 1'b0, act_rst = 1'b0, lp_hold = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h5A;
    logic [CNT_W-1:0] count_o;
    logic irq_o, rst_req_o, wdt_flag_o;

    int tests = 0, fails = 0, cyc = 0;
    bit chk_on = 1'b0;

    // model state
    int m_st, m_pre, m_cnt;
    bit m_strap, m_arm, m_irq, m_rr, m_pend, m_flag, m_rq;

    always #4 clk = ~clk;

    wdt_keyed_watchdog #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_hold(strap_hold),
        .div_sel(div_sel), .act_rst(act_rst), .lp_hold(lp_hold),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count_o(count_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
        .wdt_flag_o(wdt_flag_o)
    );

    function automatic int ratio(bit sel);
        return sel ? DIV_HI : DIV_LO;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // requirement-level reference model
    always @(posedge clk) begin
        bit en, refr, tk, uf;
        cyc++;
        if (!por_n) begin
            m_pend = 0; m_flag = 0; m_rq = 0;
        end else begin
            if (!rst_n && m_rq) begin m_flag = m_pend; m_pend = 0; end
            else if (m_rr) m_pend = 1;
            m_rq = rst_n;
        end
        if (!rst_n) begin
            m_strap = strap_hold; m_st = 0; m_pre = 0; m_cnt = FULL;
            m_arm = 0; m_irq = 0; m_rr = 0;
        end else begin
            en   = (m_st == 2) && !lp_hold;
            refr = wr_en && !wr_sel && m_arm && wr_data == 8'hFF;
            tk   = en && m_pre >= ratio(div_sel) - 1;
            uf   = tk && m_cnt == 0 && !refr;
            m_irq = uf && !act_rst;
            m_rr  = uf && act_rst;
            if (en) m_pre = tk ? 0 : m_pre + 1;
            if (refr || uf) m_cnt = FULL;
            else if (tk) m_cnt = m_cnt - 1;
            if (wr_en && !wr_sel) m_arm = (wr_data == 8'h00);
            if (m_st == 0) m_st = m_strap ? 1 : 2;
            else if (m_st == 1 && wr_en && wr_sel) m_st = 2;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            check("R1 count", count_o, m_cnt);
            check("R8 irq", irq_o, m_irq);
            check("R8 rst_req", rst_req_o, m_rr);
            check("R10 flag", wdt_flag_o, m_flag);
        end
    end

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk); chk_on = 0; rst_n = 0; strap_hold = strap;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 count", count_o, FULL);
        check("R11 irq", irq_o, 0);
        check("R11 rst_req", rst_req_o, 0);
        rst_n = 1;
        @(negedge clk); chk_on = 1;
    endtask

    task automatic period(output int n);
        n = 0;
        do @(negedge clk); while (!irq_o && !rst_req_o);
        do begin @(negedge clk); n++; end while (!irq_o && !rst_req_o);
    endtask

    initial begin
        int n;
        repeat (2) @(negedge clk);
        por_n = 1;
        do_reset(0);
        // R1 / R2: period in both ratios
        period(n); check("R1 period lo", n, DIV_LO * (1 << CNT_W));
        @(negedge clk); div_sel = 1;
        period(n); period(n); check("R2 period hi", n, DIV_HI * (1 << CNT_W));
        div_sel = 0;
        // R3: arm, repeated arm, fire
        wr(0, 8'h00); wr(0, 8'h00); wr(0, 8'hFF);
        check("R3 reload", count_o, FULL);
        // R3: wrong value disarms, FF unarmed ignored
        repeat (10) @(negedge clk);
        wr(0, 8'h00); wr(0, 8'h12); n = count_o;
        wr(0, 8'hFF); check("R3 no reload", (count_o == FULL) ? 1 : 0, 0);
        // R7: freeze holds count
        lp_hold = 1; n = count_o; repeat (20) @(negedge clk);
        check("R7 held", count_o, n); lp_hold = 0;
        // R6: start write while running ignored (model tracks counting)
        wr(1, 8'h00);
        // R9: refresh collides with underflow tick
        do @(negedge clk); while (!(m_cnt == 0 && m_pre == DIV_LO - 2));
        wr_en = 1; wr_sel = 0; wr_data = 8'h00;
        @(negedge clk); wr_data = 8'hFF;
        @(negedge clk); wr_en = 0;
        check("R9 count", count_o, FULL); check("R9 irq", irq_o, 0);
        // random mix, R4 prescaler phase kept by model
        void'($urandom(1234));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            wr_en = ($urandom % 6) == 0;
            wr_sel = ($urandom % 10) == 0;
            case ($urandom % 4)
                0, 1: wr_data = 8'h00;
                2: wr_data = 8'hFF;
                default: wr_data = 8'($urandom);
            endcase
            if (($urandom % 40) == 0) lp_hold = ~lp_hold;
            if (($urandom % 300) == 0) div_sel = ~div_sel;
            if (($urandom % 200) == 0) act_rst = ~act_rst;
        end
        @(negedge clk); wr_en = 0; lp_hold = 0; div_sel = 0;
        // R5: strap 1 waits, later strap change ignored
        do_reset(1); strap_hold = 0;
        repeat (30) @(negedge clk);
        check("R5 waiting", count_o, FULL);
        wr(1, 8'hA7);
        repeat (DIV_LO * 2 + 2) @(negedge clk);
        check("R5 started", (count_o < FULL) ? 1 : 0, 1);
        // R10: watchdog reset sets flag, plain reset clears it
        act_rst = 1; period(n);
        @(negedge clk);
        do_reset(0); check("R10 set", wdt_flag_o, 1);
        do_reset(0); check("R10 clear", wdt_flag_o, 0);
        act_rst = 0;
        repeat (50) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule